// File: doc/BRIEF.md
# Streaming Haar LL2 Window Reducer

The block turns a 24 x 100 window of 8-bit pixels into the 6 x 25 second-level Haar low-pass subband. It does this in one step, with no cascade of separable filter levels. Each output coefficient is the mean of one non-overlapping 4 x 4 tile of the window. The mean is the tile sum with its binary point moved four places, so the block needs no divider.

A window begins with a start pulse. The pixels then arrive one whole tile per cycle on a 128-bit strip bus, qualified by a valid flag. Tiles come in row-major tile order, and each accepted strip moves four columns further across the window. One coefficient leaves per cycle, with a valid flag and its linear index m = 25i + j. The last coefficient carries a last flag, and a done pulse follows it. A classifier that takes its inputs in index order can consume the stream directly.

Top module: `haar_ll2_reducer`

## Requirements
- R1: While reset is held and after its release, coef_valid_o, coef_last_o, done_o and busy_o are 0.
- R2: The coefficient for tile (i, j) is the 12-bit sum of the pixels p(4i+k, 4j+l) for k and l from 0 to 3. It reads as an unsigned 8.4 fixed-point mean: 0 for an all-zero tile and 4080 for an all-255 tile. Byte (4k+l) of pix_strip_i, at bits [(4k+l)*8 +: 8], holds p(4i+k, 4j+l). Strip row k therefore carries only window rows congruent to k mod 4.
- R3: A strip accepted in cycle c produces its coefficient, with coef_valid_o high, in cycle c+2.
- R4: Strips accepted on consecutive cycles produce coefficients on consecutive cycles, one per cycle, with no bubble.
- R5: coef_idx_o is the count of strips accepted before this one in the current window. It runs 0..149 in acceptance order, which is the tile index 25i + j.
- R6: The coefficient with index 149 has coef_last_o = 1. done_o pulses for one cycle in the cycle after it, and busy_o falls in that same cycle. Exactly 150 coefficients are emitted per window.
- R7: A start pulse while busy_o is 1 is ignored. The index sequence and the window in progress continue unchanged.
- R8: Strips offered while the block is idle, or after the 150th strip of a window has been accepted, produce no coefficient.
- R9: A cycle with pix_valid_i low inside a window produces no coefficient. The index resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a window when idle |
| pix_valid_i | input | 1 | Strip on pix_strip_i is valid |
| pix_strip_i | input | 128 | One 4 x 4 tile; byte 4k+l is tile row k, column l |
| busy_o | output | 1 | A window is in progress |
| coef_valid_o | output | 1 | coef_o and coef_idx_o are valid |
| coef_o | output | 12 | Tile mean, unsigned 8.4 fixed point |
| coef_idx_o | output | 8 | Linear coefficient index 25i + j |
| coef_last_o | output | 1 | Marks coefficient 149 |
| done_o | output | 1 | One-cycle pulse after the last coefficient |

## Verification
Each coefficient is due exactly two cycles after its strip is accepted. The done pulse is due exactly one cycle after the coefficient flagged last. The bench notes the cycle in which it offers every strip. At each falling edge it compares any valid output against that cycle plus two, against its own tile-sum model and against the next expected index. It also compares done against the cycle of the last coefficient plus one. Because checks happen at falling edges, a result that is early, late or missing shows up as a mismatch in a specific cycle rather than as a race at the clock edge.

// File: rtl/haar_ll2_pkg.sv
package haar_ll2_pkg;

    // Window controller phases
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,   // waiting for start
        WIN_FILL  = 2'd1,   // accepting strips
        WIN_DRAIN = 2'd2    // all strips taken, waiting for the tail coefficient
    } win_state_e;

endpackage

// File: rtl/haar_window_ctrl.sv
module haar_window_ctrl
    import haar_ll2_pkg::*;
#(
    parameter int NCOEF = 150,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pix_valid_i,
    input  logic             tail_seen_i,
    output logic             accept_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCOEF - 1);

    typedef struct packed {
        win_state_e       state;
        logic [IDX_W-1:0] cnt;
        logic             done;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        accept_o = 1'b0;
        case (r_q.state)
            WIN_IDLE: begin
                if (start_i) begin
                    r_d.state = WIN_FILL;
                    r_d.cnt   = '0;
                end
            end
            WIN_FILL: begin
                // start_i is not looked at here (R7)
                if (pix_valid_i) begin
                    accept_o = 1'b1;
                    if (r_q.cnt == LAST_IDX) begin
                        r_d.state = WIN_DRAIN;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            WIN_DRAIN: begin
                if (tail_seen_i) begin
                    r_d.state = WIN_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: WIN_IDLE, cnt: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign idx_o  = r_q.cnt;
    assign last_o = (r_q.cnt == LAST_IDX);
    assign busy_o = (r_q.state != WIN_IDLE);
    assign done_o = r_q.done;

    // R7 / R9: an idle cycle in the fill phase keeps the count, whatever start does
    a_r7_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == WIN_FILL && !pix_valid_i) |=> (r_q.state == WIN_FILL && $stable(r_q.cnt)));

    // R6: done only follows the tail coefficient
    a_r6_done_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(tail_seen_i));

    // R5: count never leaves the index range
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST_IDX);

endmodule

// File: rtl/haar_strip_rowsum.sv
module haar_strip_rowsum #(
    parameter int PIX_W = 8,
    parameter int TILE  = 4,
    parameter int IDX_W = 8,
    parameter int RS_W  = PIX_W + $clog2(TILE)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid_i,
    input  logic [IDX_W-1:0]           in_idx_i,
    input  logic                       in_last_i,
    input  logic [TILE*TILE*PIX_W-1:0] strip_i,
    output logic                       out_valid_o,
    output logic [IDX_W-1:0]           out_idx_o,
    output logic                       out_last_o,
    output logic [TILE*RS_W-1:0]       out_rows_o
);

    localparam int ROW_BITS = TILE * PIX_W;
    localparam int ROW_MAX  = TILE * ((1 << PIX_W) - 1);

    typedef struct packed {
        logic                       valid;
        logic [IDX_W-1:0]           idx;
        logic                       last;
        logic [TILE-1:0][RS_W-1:0]  rows;
    } stage_t;

    stage_t st_q, st_d;
    logic [TILE-1:0][RS_W-1:0] row_sum;

    function automatic logic [RS_W-1:0] add_row(input logic [ROW_BITS-1:0] row);
        logic [RS_W-1:0] acc;
        acc = '0;
        for (int l = 0; l < TILE; l++) begin
            acc = acc + RS_W'(row[l*PIX_W +: PIX_W]);
        end
        return acc;
    endfunction

    // Strip row k holds only window rows congruent to k mod TILE
    for (genvar k = 0; k < TILE; k++) begin : g_row
        assign row_sum[k] = add_row(strip_i[k*ROW_BITS +: ROW_BITS]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            st_d.idx  = in_idx_i;
            st_d.last = in_last_i;
            st_d.rows = row_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.valid;
    assign out_idx_o   = st_q.idx;
    assign out_last_o  = st_q.last;
    assign out_rows_o  = st_q.rows;

    // R2: each stored partial sum stays within the range of one tile row
    for (genvar k = 0; k < TILE; k++) begin : g_chk
        a_r2_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o |-> (int'(st_q.rows[k]) <= ROW_MAX));
    end

endmodule

// File: rtl/haar_tile_merge.sv
module haar_tile_merge #(
    parameter int TILE   = 4,
    parameter int RS_W   = 10,
    parameter int IDX_W  = 8,
    parameter int COEF_W = RS_W + $clog2(TILE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid_i,
    input  logic [IDX_W-1:0]     in_idx_i,
    input  logic                 in_last_i,
    input  logic [TILE*RS_W-1:0] in_rows_i,
    output logic                 out_valid_o,
    output logic [COEF_W-1:0]    out_coef_o,
    output logic [IDX_W-1:0]     out_idx_o,
    output logic                 out_last_o
);

    typedef struct packed {
        logic               valid;
        logic [COEF_W-1:0]  coef;
        logic [IDX_W-1:0]   idx;
        logic               last;
    } out_t;

    out_t o_q, o_d;
    logic [COEF_W-1:0] tile_sum;

    always_comb begin
        tile_sum = '0;
        for (int k = 0; k < TILE; k++) begin
            tile_sum = tile_sum + COEF_W'(in_rows_i[k*RS_W +: RS_W]);
        end
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = in_valid_i;
        o_d.last  = in_valid_i & in_last_i;
        if (in_valid_i) begin
            // binary point moved by 2*log2(TILE): the sum is the mean
            o_d.coef = tile_sum;
            o_d.idx  = in_idx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid_o = o_q.valid;
    assign out_coef_o  = o_q.coef;
    assign out_idx_o   = o_q.idx;
    assign out_last_o  = o_q.last;

    // R3: an output only appears one stage after a valid partial-sum stage
    a_r3_stage_follow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i));

    // R6: the last flag never stands alone
    a_r6_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

endmodule

// File: rtl/haar_ll2_reducer.sv
module haar_ll2_reducer #(
    parameter int PIX_W    = 8,
    parameter int TILE     = 4,
    parameter int WIN_ROWS = 24,
    parameter int WIN_COLS = 100,
    parameter int STRIP_W  = TILE * TILE * PIX_W,
    parameter int COEF_W   = PIX_W + 2 * $clog2(TILE),
    parameter int IDX_W    = $clog2((WIN_ROWS / TILE) * (WIN_COLS / TILE))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               pix_valid_i,
    input  logic [STRIP_W-1:0] pix_strip_i,
    output logic               busy_o,
    output logic               coef_valid_o,
    output logic [COEF_W-1:0]  coef_o,
    output logic [IDX_W-1:0]   coef_idx_o,
    output logic               coef_last_o,
    output logic               done_o
);

    localparam int TILE_ROWS = WIN_ROWS / TILE;
    localparam int TILE_COLS = WIN_COLS / TILE;
    localparam int NCOEF     = TILE_ROWS * TILE_COLS;
    localparam int RS_W      = PIX_W + $clog2(TILE);
    localparam int COEF_MAX  = TILE * TILE * ((1 << PIX_W) - 1);

    logic             accept;
    logic [IDX_W-1:0] acc_idx;
    logic             acc_last;
    logic             s1_valid;
    logic [IDX_W-1:0] s1_idx;
    logic             s1_last;
    logic [TILE*RS_W-1:0] s1_rows;
    logic             tail_seen;

    haar_window_ctrl #(
        .NCOEF (NCOEF),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pix_valid_i (pix_valid_i),
        .tail_seen_i (tail_seen),
        .accept_o    (accept),
        .idx_o       (acc_idx),
        .last_o      (acc_last),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    haar_strip_rowsum #(
        .PIX_W (PIX_W),
        .TILE  (TILE),
        .IDX_W (IDX_W),
        .RS_W  (RS_W)
    ) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (accept),
        .in_idx_i    (acc_idx),
        .in_last_i   (acc_last),
        .strip_i     (pix_strip_i),
        .out_valid_o (s1_valid),
        .out_idx_o   (s1_idx),
        .out_last_o  (s1_last),
        .out_rows_o  (s1_rows)
    );

    haar_tile_merge #(
        .TILE   (TILE),
        .RS_W   (RS_W),
        .IDX_W  (IDX_W),
        .COEF_W (COEF_W)
    ) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (s1_valid),
        .in_idx_i    (s1_idx),
        .in_last_i   (s1_last),
        .in_rows_i   (s1_rows),
        .out_valid_o (coef_valid_o),
        .out_coef_o  (coef_o),
        .out_idx_o   (coef_idx_o),
        .out_last_o  (coef_last_o)
    );

    assign tail_seen = coef_valid_o & coef_last_o;

    // R5: every emitted index lies inside the subband
    a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid_o |-> (int'(coef_idx_o) < NCOEF));

    // R2: a tile mean cannot exceed the all-white value
    a_r2_coef_max: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid_o |-> (int'(coef_o) <= COEF_MAX));

    // R6: the last flag sits on the final index only
    a_r6_last_idx: assert property (@(posedge clk) disable iff (!rst_n)
        coef_last_o |-> (int'(coef_idx_o) == NCOEF - 1));

    // R6: done follows the last coefficient by one cycle
    a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(coef_valid_o && coef_last_o));

    // R4: consecutive outputs carry consecutive indices
    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid_o && !coef_last_o) |=>
            (!coef_valid_o || (int'(coef_idx_o) == int'($past(coef_idx_o)) + 1)));

endmodule

// File: tb/sim_haar_ll2_reducer.sv
`timescale 1ns/1ps
module sim_haar_ll2_reducer;

    localparam int NCOEF = 150;
    localparam int TCOLS = 25;

    // mode, seed, gaps, start-while-busy, flat expected value (-1: use model)
    localparam int TAB [6][5] = '{
        '{0,   0, 0, 0, 0},
        '{1,   0, 0, 0, 4080},
        '{2,   7, 1, 0, 112},
        '{3,  11, 0, 1, -1},
        '{3, 200, 1, 1, -1},
        '{4,   0, 0, 0, -1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         pv = 1'b0;
    logic [127:0] strip = '0;
    logic         busy, cvalid, clast, done;
    logic [11:0]  coef;
    logic [7:0]   cidx;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int out_cnt = 0;
    int last_cyc = 0;
    int prev_cyc = 0;
    int stray = 0;
    int drv_cyc [NCOEF];
    bit win_active = 0;
    bit done_seen = 0;
    int cur_mode = 0;
    int cur_seed = 0;
    int cur_flat = -1;
    bit cur_gaps = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    haar_ll2_reducer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .pix_valid_i  (pv),
        .pix_strip_i  (strip),
        .busy_o       (busy),
        .coef_valid_o (cvalid),
        .coef_o       (coef),
        .coef_idx_o   (cidx),
        .coef_last_o  (clast),
        .done_o       (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int pix(input int mode, input int seed, input int r, input int c);
        case (mode)
            0: return 0;
            1: return 255;
            2: return seed & 255;
            3: return ((r * 131 + c * 29 + seed * 17) ^ (r * c + seed)) & 255;
            default: return (r * 10 + c) & 255;
        endcase
    endfunction

    function automatic logic [127:0] make_strip(input int mode, input int seed, input int m);
        logic [127:0] s;
        int ti = m / TCOLS;
        int tj = m % TCOLS;
        s = '0;
        for (int k = 0; k < 4; k++)
            for (int l = 0; l < 4; l++)
                s[(4*k+l)*8 +: 8] = 8'(pix(mode, seed, 4*ti+k, 4*tj+l));
        return s;
    endfunction

    function automatic int model(input int mode, input int seed, input int m);
        int acc = 0;
        int ti = m / TCOLS;
        int tj = m % TCOLS;
        for (int k = 0; k < 4; k++)
            for (int l = 0; l < 4; l++)
                acc += pix(mode, seed, 4*ti+k, 4*tj+l);
        return acc;
    endfunction

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cvalid) begin
                if (!win_active || out_cnt >= NCOEF) begin
                    stray++;
                    chk(0, "R8 stray coefficient", int'(cidx), -1);
                end else begin
                    int expv;
                    expv = (cur_flat >= 0) ? cur_flat : model(cur_mode, cur_seed, out_cnt);
                    chk(int'(cidx) == out_cnt, "R5 index", int'(cidx), out_cnt);
                    chk(int'(coef) == expv, "R2 coefficient", int'(coef), expv);
                    chk(cyc == drv_cyc[out_cnt] + 2, "R3 latency", cyc, drv_cyc[out_cnt] + 2);
                    if (!cur_gaps && out_cnt > 0)
                        chk(cyc == prev_cyc + 1, "R4 back-to-back", cyc, prev_cyc + 1);
                    chk(clast == (out_cnt == NCOEF - 1), "R6 last flag", int'(clast),
                        int'(out_cnt == NCOEF - 1));
                    prev_cyc = cyc;
                    if (clast) last_cyc = cyc;
                    out_cnt++;
                end
            end
            if (done) begin
                chk(win_active, "R6 done outside window", 0, 1);
                chk(out_cnt == NCOEF, "R6 coefficient count", out_cnt, NCOEF);
                chk(cyc == last_cyc + 1, "R6 done timing", cyc, last_cyc + 1);
                chk(!busy, "R6 busy falls with done", int'(busy), 0);
                done_seen = 1;
            end
        end
    end

    task automatic run_window(input int row);
        cur_mode = TAB[row][0];
        cur_seed = TAB[row][1];
        cur_gaps = TAB[row][2] != 0;
        cur_flat = TAB[row][4];
        out_cnt = 0;
        done_seen = 0;
        win_active = 1;
        @(negedge clk);
        start = 1'b1;
        pv = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int m = 0; m < NCOEF; m++) begin
            if (cur_gaps && (m % 3 == 2)) begin
                pv = 1'b0;
                @(negedge clk);   // R9 idle cycle inside the window
            end
            pv = 1'b1;
            strip = make_strip(cur_mode, cur_seed, m);
            drv_cyc[m] = cyc;
            start = (TAB[row][3] != 0) && (m == 70);  // R7 start while busy
            @(negedge clk);
            start = 1'b0;
        end
        // R8: a surplus strip after the 150th must be dropped
        pv = 1'b1;
        strip = make_strip(1, 0, 0);
        @(negedge clk);
        pv = 1'b0;
        for (int w = 0; w < 10 && !done_seen; w++) @(negedge clk);
        chk(done_seen, "R6 done pulse seen", int'(done_seen), 1);
        @(negedge clk);
        chk(!done, "R6 done is one cycle", int'(done), 0);
        win_active = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!cvalid && !clast && !done && !busy, "R1 during reset",
            int'({cvalid, clast, done, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cvalid && !clast && !done && !busy, "R1 after release",
            int'({cvalid, clast, done, busy}), 0);

        // R8: strips while idle give nothing
        pv = 1'b1;
        strip = make_strip(1, 0, 0);
        repeat (3) @(negedge clk);
        pv = 1'b0;
        repeat (3) @(negedge clk);
        chk(stray == 0 && !busy, "R8 idle strips ignored", stray, 0);

        // Table of windows
        for (int t = 0; t < 6; t++) begin
            run_window(t);
            repeat (2) @(negedge clk);
        end
        chk(stray == 0, "R8 no stray outputs", stray, 0);

        // R1: reset in the middle of a window
        cur_mode = 3; cur_seed = 5; cur_flat = -1; cur_gaps = 0;
        out_cnt = 0; win_active = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int m = 0; m < 10; m++) begin
            pv = 1'b1;
            strip = make_strip(cur_mode, cur_seed, m);
            drv_cyc[m] = cyc;
            @(negedge clk);
        end
        pv = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!cvalid && !done && !busy, "R1 mid-window reset",
            int'({cvalid, done, busy}), 0);
        win_active = 0;
        rst_n = 1'b1;
        @(negedge clk);
        run_window(1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule